// File: doc/BRIEF.md
# Single-Accumulator Instruction Executor

This block is the execute stage of a small 8-bit processor that keeps all of its working state in one accumulator plus a carry flag and a zero flag. Each clock cycle it takes one 12-bit instruction word. The upper four bits select the operation. The lower eight bits hold either a constant or a data-RAM address. The block finishes that instruction within the same cycle.

Arithmetic and logic operations combine the accumulator with either the constant or the byte that the data RAM returns for the addressed location. The result is written back to the accumulator. A store operation drives the accumulator onto the RAM write port.

The program counter and the RAM bank mapper live in neighbouring blocks. This block only decodes the instructions meant for them and raises one-cycle strobes, each with its value. Higher-level operations such as subtraction, loading and clearing are built by software from short sequences of these primitives.

Top module: `accum_core`

## Requirements
- R1: While `rstN` is low, the accumulator, carry and zero are all 0. The reset is asynchronous.
- R2: `ramAddr` always equals `instr[7:0]`. The memory forms take their second operand from `ramRdata`: opcode 0x0 is NOR, 0x2 is AND and 0x4 is ADD. Each writes its result to the accumulator at the clock edge.
- R3: The immediate forms take their second operand from `instr[7:0]`: opcode 0x1 is NOR, 0x3 is AND and 0x5 is ADD.
- R4: ADD and ADDI set carry to the bit-8 carry-out of the 9-bit sum, which clears it when there is no overflow. Every other opcode leaves carry unchanged.
- R5: Every opcode that writes the accumulator (0x0 to 0x7) sets zero to 1 exactly when the new accumulator is 0x00. Every other opcode leaves zero unchanged.
- R6: Opcode 0x6 shifts the accumulator right by one bit and 0x7 shifts it left by one bit. Both fill with 0.
- R7: Opcode 0x8 raises `ramWe` in that cycle, with `ramWdata` equal to the accumulator. The accumulator and flags are left unchanged. `ramWe` is low for every other opcode.
- R8: Opcodes 0x9 and 0xA raise `pcLoadLow` only when carry is 0 or zero is 1. For 0x9 `pcLowValue` is `instr[7:0]`; for 0xA it is `ramRdata`.
- R9: Opcode 0xB raises `pcLoadLow` without any condition, with `pcLowValue` equal to `instr[7:0]`.
- R10: Opcode 0xC raises `pcHighArm` and opcode 0xD raises `bankLoad`. `ctlValue` carries `instr[7:0]`. At most one of `ramWe`, `pcLoadLow`, `pcHighArm` and `bankLoad` is high in any cycle.
- R11: Opcodes 0xE and 0xF raise no strobe and leave the accumulator and both flags unchanged.
- R12: Instruction sequences work as composite operations. NORI 0x00 inverts the accumulator. NORI 0xFF clears it. The sequence NOT, ADD m, ANDI 0xFF, ADDI 1 leaves RAM[m] minus the old accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instr | input | 12 | Instruction word: opcode in [11:8], operand in [7:0] |
| ramRdata | input | 8 | Combinational read data for `ramAddr` |
| ramAddr | output | 8 | Data RAM address (the operand field) |
| ramWdata | output | 8 | Data RAM write data (the accumulator) |
| ramWe | output | 1 | Data RAM write enable, taken by the RAM at the clock edge |
| pcLoadLow | output | 1 | Load the low byte of the program counter |
| pcLowValue | output | 8 | Value for the low byte of the program counter |
| pcHighArm | output | 1 | Arm a pending load of the program counter high byte |
| bankLoad | output | 1 | Select a new upper RAM bank |
| ctlValue | output | 8 | Value that goes with `pcHighArm` or `bankLoad` |
| accOut | output | 8 | Current accumulator |
| carryOut | output | 1 | Current carry flag |
| zeroOut | output | 1 | Current zero flag |

## Verification
The bench builds the block with its default data width of 8 bits, so the accumulator ranges over 0x00 to 0xFF. At that width the boundaries are easy to hit: an ADD whose sum is exactly 0x100 sets carry and zero together, and shifts push a 1 out of either end. The jump condition is driven through all three flag combinations that matter, using short real instruction sequences. The bench also runs a full subtract sequence and checks the difference that comes out of the accumulator.

// File: rtl/accum_pkg.sv
package accum_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOR   = 4'h0,
    OP_NORI  = 4'h1,
    OP_AND   = 4'h2,
    OP_ANDI  = 4'h3,
    OP_ADD   = 4'h4,
    OP_ADDI  = 4'h5,
    OP_SHR   = 4'h6,
    OP_SHL   = 4'h7,
    OP_STA   = 4'h8,
    OP_JCC   = 4'h9,
    OP_JPCC  = 4'hA,
    OP_LPC   = 4'hB,
    OP_LTPC  = 4'hC,
    OP_BANK  = 4'hD,
    OP_SPARE0 = 4'hE,
    OP_SPARE1 = 4'hF
  } op_e;

  typedef enum logic [2:0] {
    ALU_NOR,
    ALU_AND,
    ALU_ADD,
    ALU_SHR,
    ALU_SHL
  } alu_e;

  // Strobes from control to datapath and block edge
  typedef struct packed {
    logic accWe;
    logic carryWe;
    logic useImm;
    alu_e aluSel;
    logic ramWe;
    logic condJump;
    logic uncondJump;
    logic jumpFromRam;
    logic pcHighArm;
    logic bankLoad;
  } ctrl_t;

endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic            carryQ,
  input  logic            zeroQ,
  output ctrl_t           strb,
  output logic            pcLoadLow
);

  op_e op;
  logic jumpOk;

  assign op = op_e'(opcode);

  always_comb begin
    strb = '0;
    strb.aluSel = ALU_ADD;
    unique case (op)
      OP_NOR:  begin strb.accWe = 1'b1; strb.aluSel = ALU_NOR; end
      OP_NORI: begin strb.accWe = 1'b1; strb.aluSel = ALU_NOR; strb.useImm = 1'b1; end
      OP_AND:  begin strb.accWe = 1'b1; strb.aluSel = ALU_AND; end
      OP_ANDI: begin strb.accWe = 1'b1; strb.aluSel = ALU_AND; strb.useImm = 1'b1; end
      OP_ADD:  begin strb.accWe = 1'b1; strb.carryWe = 1'b1; end
      OP_ADDI: begin strb.accWe = 1'b1; strb.carryWe = 1'b1; strb.useImm = 1'b1; end
      OP_SHR:  begin strb.accWe = 1'b1; strb.aluSel = ALU_SHR; end
      OP_SHL:  begin strb.accWe = 1'b1; strb.aluSel = ALU_SHL; end
      OP_STA:  strb.ramWe = 1'b1;
      OP_JCC:  strb.condJump = 1'b1;
      OP_JPCC: begin strb.condJump = 1'b1; strb.jumpFromRam = 1'b1; end
      OP_LPC:  strb.uncondJump = 1'b1;
      OP_LTPC: strb.pcHighArm = 1'b1;
      OP_BANK: strb.bankLoad = 1'b1;
      default: ;
    endcase
  end

  // Conditional jump taken when no carry or result was zero
  assign jumpOk    = !carryQ || zeroQ;
  assign pcLoadLow = strb.uncondJump || (strb.condJump && jumpOk);

endmodule

// File: rtl/accum_dpath.sv
module accum_dpath
  import accum_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             strb,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [DATA_W-1:0] accQ,
  output logic              carryQ,
  output logic              zeroQ,
  output logic [DATA_W-1:0] pcLowValue
);

  logic [DATA_W-1:0] opB;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] result;

  assign opB = strb.useImm ? operand : ramRdata;
  assign sum = {1'b0, accQ} + {1'b0, opB};

  always_comb begin
    unique case (strb.aluSel)
      ALU_NOR: result = ~(accQ | opB);
      ALU_AND: result = accQ & opB;
      ALU_SHR: result = {1'b0, accQ[DATA_W-1:1]};
      ALU_SHL: result = {accQ[DATA_W-2:0], 1'b0};
      default: result = sum[DATA_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      carryQ <= 1'b0;
      zeroQ  <= 1'b0;
    end else begin
      if (strb.accWe) begin
        accQ  <= result;
        zeroQ <= (result == '0);
      end
      if (strb.carryWe) begin
        carryQ <= sum[DATA_W];
      end
    end
  end

  assign pcLowValue = strb.jumpFromRam ? ramRdata : operand;

endmodule

// File: rtl/accum_core.sv
module accum_core
  import accum_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int INSTR_W = OP_W + DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  ramRdata,
  output logic [DATA_W-1:0]  ramAddr,
  output logic [DATA_W-1:0]  ramWdata,
  output logic               ramWe,
  output logic               pcLoadLow,
  output logic [DATA_W-1:0]  pcLowValue,
  output logic               pcHighArm,
  output logic               bankLoad,
  output logic [DATA_W-1:0]  ctlValue,
  output logic [DATA_W-1:0]  accOut,
  output logic               carryOut,
  output logic               zeroOut
);

  ctrl_t             strb;
  logic [DATA_W-1:0] operand;

  assign operand = instr[DATA_W-1:0];

  accum_ctrl u_ctrl (
    .opcode    (instr[INSTR_W-1:DATA_W]),
    .carryQ    (carryOut),
    .zeroQ     (zeroOut),
    .strb      (strb),
    .pcLoadLow (pcLoadLow)
  );

  accum_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .operand    (operand),
    .ramRdata   (ramRdata),
    .accQ       (accOut),
    .carryQ     (carryOut),
    .zeroQ      (zeroOut),
    .pcLowValue (pcLowValue)
  );

  assign ramAddr   = operand;
  assign ramWdata  = accOut;
  assign ramWe     = strb.ramWe;
  assign pcHighArm = strb.pcHighArm;
  assign bankLoad  = strb.bankLoad;
  assign ctlValue  = operand;

endmodule

// File: rtl/accum_core_chk.sv
module accum_core_chk #(
  parameter int DATA_W = 8,
  localparam int INSTR_W = 4 + DATA_W
) (
  input logic               clk,
  input logic               rstN,
  input logic [INSTR_W-1:0] instr,
  input logic [DATA_W-1:0]  ramRdata,
  input logic [DATA_W-1:0]  ramAddr,
  input logic [DATA_W-1:0]  ramWdata,
  input logic               ramWe,
  input logic               pcLoadLow,
  input logic [DATA_W-1:0]  pcLowValue,
  input logic               pcHighArm,
  input logic               bankLoad,
  input logic [DATA_W-1:0]  ctlValue,
  input logic [DATA_W-1:0]  accOut,
  input logic               carryOut,
  input logic               zeroOut
);

  logic [3:0] opc;
  logic isAdd, writesAcc, isSpare, isCond;
  assign opc       = instr[INSTR_W-1:DATA_W];
  assign isAdd     = (opc == 4'h4) || (opc == 4'h5);
  assign writesAcc = (opc <= 4'h7);
  assign isSpare   = (opc >= 4'hE);
  assign isCond    = (opc == 4'h9) || (opc == 4'hA);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (accOut == '0 && !carryOut && !zeroOut));

  // R4
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isAdd |=> $stable(carryOut));

  // R5
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !writesAcc |=> $stable(zeroOut));

  // R5
  zero_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    writesAcc |=> (zeroOut == (accOut == '0)));

  // R7
  store_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> $stable(accOut));

  // R8
  jump_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isCond && pcLoadLow) |-> (!carryOut || zeroOut));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ramWe, pcLoadLow, pcHighArm, bankLoad}));

  // R11
  spare_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    isSpare |-> !(ramWe || pcLoadLow || pcHighArm || bankLoad));

  // R11
  spare_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    isSpare |=> ($stable(accOut) && $stable(carryOut) && $stable(zeroOut)));

endmodule

bind accum_core accum_core_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/accum_core_bench.sv
module accum_core_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] instr = '0;
  logic [7:0]  ramRdata = '0;
  logic [7:0]  ramAddr, ramWdata, pcLowValue, ctlValue, accOut;
  logic        ramWe, pcLoadLow, pcHighArm, bankLoad, carryOut, zeroOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  accum_core u_accum_core (
    .clk(clk), .rstN(rstN), .instr(instr), .ramRdata(ramRdata),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .ramWe(ramWe),
    .pcLoadLow(pcLoadLow), .pcLowValue(pcLowValue), .pcHighArm(pcHighArm),
    .bankLoad(bankLoad), .ctlValue(ctlValue), .accOut(accOut),
    .carryOut(carryOut), .zeroOut(zeroOut)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Apply an instruction after a falling edge and let combinational outputs settle
  task automatic drive(input logic [3:0] op, input logic [7:0] opnd, input logic [7:0] rd);
    @(negedge clk);
    instr = {op, opnd};
    ramRdata = rd;
    #1;
  endtask

  // Drive, clock it in, and return at the next falling edge
  task automatic exec(input logic [3:0] op, input logic [7:0] opnd, input logic [7:0] rd);
    drive(op, opnd, rd);
    @(negedge clk);
    instr = 12'hE00;
  endtask

  task automatic expectState(input string req, input logic [7:0] a, input logic c, input logic z);
    #1;
    check(req, "acc", accOut, a);
    check(req, "carry", carryOut, c);
    check(req, "zero", zeroOut, z);
  endtask

  task automatic t_reset;
    expectState("R1", 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_logic;
    exec(4'h1, 8'hFF, 8'h00); expectState("R12", 8'h00, 1'b0, 1'b1);
    exec(4'h5, 8'h5A, 8'h00); expectState("R3", 8'h5A, 1'b0, 1'b0);
    exec(4'h1, 8'h00, 8'h00); expectState("R12", 8'hA5, 1'b0, 1'b0);
    exec(4'h3, 8'h0F, 8'h00); expectState("R3", 8'h05, 1'b0, 1'b0);
    drive(4'h2, 8'h33, 8'h04);
    check("R2", "ramAddr", ramAddr, 8'h33);
    @(negedge clk); instr = 12'hE00;
    expectState("R2", 8'h04, 1'b0, 1'b0);
    exec(4'h0, 8'h40, 8'hF0); expectState("R2", 8'h0B, 1'b0, 1'b0);
    // 0x0B + 0xF5 = 0x100: carry and zero together
    exec(4'h4, 8'h41, 8'hF5); expectState("R4", 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_shift;
    exec(4'h1, 8'hFF, 8'h00); expectState("R4", 8'h00, 1'b1, 1'b1);
    exec(4'h5, 8'h81, 8'h00); expectState("R4", 8'h81, 1'b0, 1'b0);
    exec(4'h7, 8'h00, 8'h00); expectState("R6", 8'h02, 1'b0, 1'b0);
    exec(4'h5, 8'hFF, 8'h00); expectState("R4", 8'h01, 1'b1, 1'b0);
    exec(4'h6, 8'h00, 8'h00); expectState("R6", 8'h00, 1'b1, 1'b1);
    exec(4'h5, 8'h80, 8'h00); expectState("R4", 8'h80, 1'b0, 1'b0);
    exec(4'h7, 8'h00, 8'h00); expectState("R6", 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_store;
    exec(4'h5, 8'h3C, 8'h00);
    drive(4'h8, 8'h9A, 8'h00);
    check("R7", "ramWe", ramWe, 1);
    check("R7", "ramAddr", ramAddr, 8'h9A);
    check("R7", "ramWdata", ramWdata, 8'h3C);
    @(negedge clk); instr = 12'hE00;
    expectState("R7", 8'h3C, 1'b0, 1'b0);
    drive(4'h5, 8'h00, 8'h00);
    check("R7", "ramWe on ADDI", ramWe, 0);
    @(negedge clk); instr = 12'hE00;
  endtask

  task automatic t_jump;
    // carry 0, zero 0: taken
    drive(4'h9, 8'h44, 8'h00);
    check("R8", "JCC taken", pcLoadLow, 1);
    check("R8", "JCC value", pcLowValue, 8'h44);
    @(negedge clk); instr = 12'hE00;
    exec(4'h1, 8'hFF, 8'h00);
    exec(4'h5, 8'hFF, 8'h00);
    exec(4'h5, 8'h02, 8'h00); expectState("R8", 8'h01, 1'b1, 1'b0);
    drive(4'h9, 8'h44, 8'h00);
    check("R8", "JCC blocked", pcLoadLow, 0);
    drive(4'hA, 8'h20, 8'h66);
    check("R8", "JPCC blocked", pcLoadLow, 0);
    drive(4'hB, 8'h77, 8'h00);
    check("R9", "LPC strobe", pcLoadLow, 1);
    check("R9", "LPC value", pcLowValue, 8'h77);
    @(negedge clk); instr = 12'hE00;
    exec(4'h1, 8'hFF, 8'h00); expectState("R8", 8'h00, 1'b1, 1'b1);
    drive(4'hA, 8'h20, 8'hC8);
    check("R8", "JPCC taken", pcLoadLow, 1);
    check("R8", "JPCC value", pcLowValue, 8'hC8);
    @(negedge clk); instr = 12'hE00;
    expectState("R8", 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_ctl;
    drive(4'hC, 8'h12, 8'h00);
    check("R10", "pcHighArm", pcHighArm, 1);
    check("R10", "ctlValue", ctlValue, 8'h12);
    check("R10", "others low", {bankLoad, pcLoadLow, ramWe}, 0);
    drive(4'hD, 8'h05, 8'h00);
    check("R10", "bankLoad", bankLoad, 1);
    check("R10", "ctlValue", ctlValue, 8'h05);
    check("R10", "others low", {pcHighArm, pcLoadLow, ramWe}, 0);
    @(negedge clk); instr = 12'hE00;
    expectState("R10", 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_spare;
    exec(4'h5, 8'h07, 8'h00); expectState("R11", 8'h07, 1'b0, 1'b0);
    drive(4'hE, 8'hFF, 8'hFF);
    check("R11", "strobes E", {ramWe, pcLoadLow, pcHighArm, bankLoad}, 0);
    drive(4'hF, 8'h01, 8'hFF);
    check("R11", "strobes F", {ramWe, pcLoadLow, pcHighArm, bankLoad}, 0);
    @(negedge clk); instr = 12'hE00;
    expectState("R11", 8'h07, 1'b0, 1'b0);
  endtask

  task automatic t_subtract;
    // acc = 0x05, RAM[m] = 0x12, expect 0x0D
    exec(4'h1, 8'hFF, 8'h00);
    exec(4'h5, 8'h05, 8'h00);
    exec(4'h1, 8'h00, 8'h00); expectState("R12", 8'hFA, 1'b0, 1'b0);
    exec(4'h4, 8'h50, 8'h12); expectState("R12", 8'h0C, 1'b1, 1'b0);
    exec(4'h3, 8'hFF, 8'h00);
    exec(4'h5, 8'h01, 8'h00); expectState("R12", 8'h0D, 1'b0, 1'b0);
  endtask

  initial begin
    instr = 12'hE00;
    repeat (2) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_logic();
    t_shift();
    t_store();
    t_jump();
    t_ctl();
    t_spare();
    t_subtract();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule